// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block sits between a 32-bit on-chip bus and a DRAM that has multiplexed address pins and an asynchronous interface. It takes word reads and word or partial writes and sequences them onto the DRAM. First it presents the row, then it drops the row strobe, then it presents the column, and then it drops the column strobes for each byte lane. The bus holds each request while the controller inserts wait states. The controller completes the request with a one-cycle acknowledge.

A row register and a comparator remember which row was left open. A request that falls in that row skips the row phase and runs a column-only cycle. A request to a different row first closes the row for a precharge interval. A free-running interval timer requests refresh. The controller performs refresh as a column-before-row cycle between bus requests. Refresh wins over a pending request and leaves no row open.

The request side is valid/ready. A master raises `req_valid` with all request fields and holds them unchanged until it samples `req_ready` high on a rising edge. `req_ready` high is the acknowledge, and the transfer completes on that edge. There is no other back-pressure. Latency below counts rising edges: the first one is the edge at which the idle controller samples the request, and the last one is the edge after which `req_ready` reads high.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and after synchronous reset, `dram_ras_n`, `dram_we_n` and every `dram_cas_n` lane are high and `req_ready` is low. No row is open, so the first request takes T_RCD+T_CAS+2 edges.
- R2: `req_ready` is high for exactly one cycle per request, and only while `req_valid` is high. `rsp_rdata` holds the read word during that cycle.
- R3: A request to the open row (page hit) takes T_CAS+2 edges, with no row phase.
- R4: A request to a different row while a row is open raises `dram_ras_n` for T_RP cycles, then opens the new row. It takes T_RP+T_RCD+T_CAS+2 edges.
- R5: The word address `req_addr` is split as row = high ROW_BITS bits and column = low COL_BITS bits. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` while column strobes are low. Any order of access returns the correct data.
- R6: On a write, `dram_we_n` is low at least one cycle before any column strobe falls. Column strobe lane n (data bits 8n+7..8n) is low only if `req_be[n]` is 1. On a read, all lanes fall together, and `dram_dq_oe` is high only while `dram_we_n` is low.
- R7: A read returns the word last written to that address.
- R8: Refresh pulls all column strobes low while `dram_ras_n` is high and `dram_we_n` is high. On the next cycle it pulls `dram_ras_n` low for T_RFSH cycles. Refreshes are spaced REFRESH_INTERVAL cycles apart, give or take one access.
- R9: A refresh that is due when a request arrives goes first. Afterwards no row is open, so that request takes 2*T_RP+T_RFSH+2 edges plus T_RCD+T_CAS+2.
- R10: Byte lanes with `req_be` low keep their earlier contents on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Acknowledge, access complete |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables for writes |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DATA_W/8 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data toward DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data from DRAM |

## Verification
The hardest case to reach is a refresh that becomes due in the same idle cycle that a request is waiting. Only then does refresh priority, rather than mere refresh spacing, change what the bus sees. The bench issues requests back to back with no idle gaps through long sweeps, so every timer expiry lands on an idle cycle with a request already waiting. A DRAM model watches the strobes, and each such access must show the refresh-stretched latency followed by a closed-row access. The open-row register is exercised by row-major sweeps, which give hits, and by column-major sweeps, which miss every time.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_DONE,
    ST_RF_PRE,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_END
  } fpm_state_e;
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pending
);
  localparam int TW = $clog2(INTERVAL);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= TW'(INTERVAL - 1);
      pending <= 1'b0;
    end else if (cnt == '0) begin
      cnt     <= TW'(INTERVAL - 1);
      pending <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_step_counter.sv
module fpm_step_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/fpm_page_tracker.sv
module fpm_page_tracker #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                invalidate,
  input  logic [ROW_BITS-1:0] row_in,
  output logic                open,
  output logic                hit
);
  logic [ROW_BITS-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open  <= 1'b0;
      row_q <= '0;
    end else if (invalidate) begin
      open <= 1'b0;
    end else if (load) begin
      open  <= 1'b1;
      row_q <= row_in;
    end
  end

  assign hit = open && (row_q == row_in);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int DATA_W           = 32,
  parameter int ROW_BITS         = 10,
  parameter int COL_BITS         = 8,
  parameter int T_RP             = 2,
  parameter int T_RCD            = 2,
  parameter int T_CAS            = 2,
  parameter int T_RFSH           = 4,
  parameter int REFRESH_INTERVAL = 780
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           req_valid,
  output logic                                           req_ready,
  input  logic                                           req_write,
  input  logic [ROW_BITS+COL_BITS-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                              req_wdata,
  input  logic [DATA_W/8-1:0]                            req_be,
  output logic [DATA_W-1:0]                              rsp_rdata,
  output logic [(ROW_BITS>COL_BITS?ROW_BITS:COL_BITS)-1:0] dram_addr,
  output logic                                           dram_ras_n,
  output logic [DATA_W/8-1:0]                            dram_cas_n,
  output logic                                           dram_we_n,
  output logic [DATA_W-1:0]                              dram_dq_out,
  output logic                                           dram_dq_oe,
  input  logic [DATA_W-1:0]                              dram_dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int DA_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int CW    = $clog2(T_RP + T_RCD + T_CAS + T_RFSH + 1);

  fpm_state_e state, nstate;
  logic rf_pending, step_zero, page_open, page_hit;
  logic [ROW_BITS-1:0] req_row;
  logic [COL_BITS-1:0] req_col;
  logic [DATA_W-1:0]   rdata_q;

  assign req_row = req_addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign req_col = req_addr[COL_BITS-1:0];

  function automatic logic [CW-1:0] span(fpm_state_e s);
    case (s)
      ST_PRE, ST_RF_PRE, ST_RF_END: span = CW'(T_RP - 1);
      ST_ROW:                       span = CW'(T_RCD - 1);
      ST_CAS:                       span = CW'(T_CAS - 1);
      ST_RF_RAS:                    span = CW'(T_RFSH - 1);
      default:                      span = '0;
    endcase
  endfunction

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE: begin
        if (rf_pending)     nstate = ST_RF_PRE;
        else if (req_valid) nstate = page_hit ? ST_COL : (page_open ? ST_PRE : ST_ROW);
      end
      ST_PRE:    if (step_zero) nstate = ST_ROW;
      ST_ROW:    if (step_zero) nstate = ST_COL;
      ST_COL:    nstate = ST_CAS;
      ST_CAS:    if (step_zero) nstate = ST_DONE;
      ST_DONE:   nstate = ST_IDLE;
      ST_RF_PRE: if (step_zero) nstate = ST_RF_CAS;
      ST_RF_CAS: nstate = ST_RF_RAS;
      ST_RF_RAS: if (step_zero) nstate = ST_RF_END;
      ST_RF_END: if (step_zero) nstate = ST_IDLE;
      default:   nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nstate;
  end

  always_ff @(posedge clk) begin
    if (rst)                            rdata_q <= '0;
    else if (state == ST_CAS && step_zero) rdata_q <= dram_dq_in;
  end

  fpm_step_counter #(.W(CW)) u_step (
    .clk(clk), .rst(rst),
    .load(nstate != state), .load_val(span(nstate)),
    .zero(step_zero)
  );

  fpm_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_rtmr (
    .clk(clk), .rst(rst),
    .take(state == ST_IDLE && nstate == ST_RF_PRE),
    .pending(rf_pending)
  );

  fpm_page_tracker #(.ROW_BITS(ROW_BITS)) u_page (
    .clk(clk), .rst(rst),
    .load(state != ST_ROW && nstate == ST_ROW),
    .invalidate(state == ST_IDLE && (nstate == ST_PRE || nstate == ST_RF_PRE)),
    .row_in(req_row),
    .open(page_open), .hit(page_hit)
  );

  logic col_phase, cas_phase, rf_strobe;
  assign col_phase = (state == ST_COL) || (state == ST_CAS);
  assign cas_phase = (state == ST_CAS);
  assign rf_strobe = (state == ST_RF_CAS) || (state == ST_RF_RAS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dram_cas_n[l] = !(rf_strobe || (cas_phase && (!req_write || req_be[l])));
  end

  assign dram_ras_n  = !(page_open || state == ST_RF_RAS);
  assign dram_we_n   = !(req_write && col_phase);
  assign dram_dq_oe  = req_write && col_phase;
  assign dram_dq_out = req_wdata;
  assign dram_addr   = col_phase ? DA_W'(req_col) : DA_W'(req_row);
  assign req_ready   = (state == ST_DONE);
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe
);
  // R2: acknowledge lasts one cycle
  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
  // R2: acknowledge only for a presented request
  p_ready_valid_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> req_valid);
  // R6: write enable set up before column strobes fall
  p_we_setup_r6: assert property (@(posedge clk) disable iff (rst)
    (!dram_we_n && !(&dram_cas_n) && $past(&dram_cas_n)) |-> $past(!dram_we_n));
  // R6: data driven only on writes
  p_oe_write_r6: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> !dram_we_n);
  // R8: refresh keeps write enable high
  p_cbr_we_r8: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n && !(&dram_cas_n)) |-> dram_we_n);
  // R8: row strobe follows column strobes in refresh
  p_cbr_order_r8: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n && !(&dram_cas_n)) |=> !dram_ras_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.LANES(DATA_W/8)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
  .dram_dq_oe(dram_dq_oe)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int RB = 3, CB = 3, T_RP = 2, T_RCD = 2, T_CAS = 2, T_RFSH = 3, RI = 300;
  localparam int NW = 1 << (RB + CB);
  localparam int L_HIT = T_CAS + 2;
  localparam int L_CLOSED = T_RCD + T_CAS + 2;
  localparam int L_MISS = T_RP + T_RCD + T_CAS + 2;
  localparam int L_RF = 2 * T_RP + T_RFSH + 2 + L_CLOSED;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [RB+CB-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, dram_dq_out, dram_dq_in;
  logic [3:0] req_be = '0, dram_cas_n;
  logic [2:0] dram_addr;
  logic dram_ras_n, dram_we_n, dram_dq_oe;

  always #10 clk = ~clk;

  fpm_dram_ctrl #(.DATA_W(32), .ROW_BITS(RB), .COL_BITS(CB), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RFSH(T_RFSH), .REFRESH_INTERVAL(RI)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  // DRAM model
  logic [31:0] mem [NW];
  logic [31:0] shadow [NW];
  logic [RB-1:0] m_row = '0;
  logic m_ras_prev = 1'b1;
  assign dram_dq_in = mem[{m_row, dram_addr}];
  always @(posedge clk) begin
    if (!dram_ras_n && m_ras_prev) m_row <= dram_addr;
    m_ras_prev <= dram_ras_n;
    if (!dram_ras_n && !dram_we_n)
      for (int l = 0; l < 4; l++)
        if (!dram_cas_n[l]) mem[{m_row, dram_addr}][8*l +: 8] <= dram_dq_out[8*l +: 8];
  end

  int n_chk = 0, n_fail = 0, cyc = 0, rf_count = 0, rf_last = 0, rf_in_access = 0;
  bit in_flight = 0, rf_during = 0, bk_open = 0, finished = 0;
  logic [RB-1:0] bk_row = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // refresh and strobe monitor
  always @(negedge clk) if (!rst) begin
    if (dram_ras_n && !(&dram_cas_n)) begin
      check(dram_we_n == 1'b1, "R8 we_n in refresh", dram_we_n, 1);
      if (rf_count > 0)
        check((cyc - rf_last) >= RI - 12 && (cyc - rf_last) <= RI + 12, "R8 refresh spacing",
              cyc - rf_last, RI);
      rf_last = cyc;
      rf_count++;
      bk_open = 0;
      if (in_flight) rf_during = 1;
    end
    if (!dram_we_n && !(&dram_cas_n))
      check(dram_cas_n == ~req_be, "R6 write lane strobes", dram_cas_n, ~req_be);
    if (dram_we_n && !dram_ras_n && !(&dram_cas_n))
      check(dram_cas_n == 4'h0, "R6 read lane strobes", dram_cas_n, 0);
  end

  task automatic access(input bit wr, input int a, input logic [31:0] d, input logic [3:0] be,
                        input string rtag, input bit first);
    int n = 0, exp;
    string ltag;
    bit open0 = bk_open;
    logic [RB-1:0] row = RB'(a >> CB);
    req_valid = 1; req_write = wr; req_addr = (RB+CB)'(a); req_wdata = d; req_be = be;
    in_flight = 1; rf_during = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!req_ready && n < 100);
    if (rf_during) begin exp = L_RF; ltag = "R9 latency after refresh"; rf_in_access++; end
    else if (open0 && row == bk_row) begin exp = L_HIT; ltag = "R3 hit latency"; end
    else if (open0) begin exp = L_MISS; ltag = "R4 miss latency"; end
    else begin exp = L_CLOSED; ltag = first ? "R1 first access latency" : "R9 closed-row latency"; end
    check(n == exp, ltag, n, exp);
    if (wr) begin
      for (int l = 0; l < 4; l++) if (be[l]) shadow[a][8*l +: 8] = d[8*l +: 8];
    end else begin
      check(rsp_rdata == shadow[a], rtag, rsp_rdata, shadow[a]);
    end
    bk_open = 1; bk_row = row; in_flight = 0;
    @(posedge clk); #1;
    check(req_ready == 1'b0, "R2 single-cycle ready", req_ready, 0);
    req_valid = 0;
  endtask

  function automatic logic [31:0] pat(input int a, input int s);
    return 32'(a * 32'h0103_0507 + s * 32'h1111_0000) ^ 32'hA5C3_0F11;
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_we_n && (&dram_cas_n) && !req_ready, "R1 reset outputs",
          {dram_ras_n, dram_we_n, dram_cas_n, req_ready}, 7'b1111110);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(dram_ras_n && (&dram_cas_n) && !req_ready, "R1 idle after reset",
          {dram_ras_n, dram_cas_n, req_ready}, 6'b111110);
    @(posedge clk); #1;
    // row-major write sweep: hits within a row, misses across rows
    for (int a = 0; a < NW; a++) access(1, a, pat(a, 0), 4'hF, "", a == 0);
    // row-major read sweep
    for (int a = 0; a < NW; a++) access(0, a, 32'h0, 4'h0, "R7 read data", 0);
    // column-major reads: every access changes row
    for (int c = 0; c < (1 << CB); c++)
      for (int r = 0; r < (1 << RB); r++) access(0, (r << CB) | c, 32'h0, 4'h0, "R5 address split", 0);
    // byte-enable sweep on a few words
    for (int be = 1; be < 16; be++) begin
      int a = (be * 5) % NW;
      access(1, a, pat(a, be), 4'(be), "", 0);
      access(0, a, 32'h0, 4'h0, "R10 partial write merge", 0);
    end
    // idle until a refresh, then the next access must find no row open
    begin
      int c0 = rf_count;
      while (rf_count == c0) @(negedge clk);
      repeat (8) @(negedge clk);
      @(posedge clk); #1;
      access(0, 9, 32'h0, 4'h0, "R7 read after refresh", 0);
    end
    check(rf_in_access > 0, "R9 refresh ahead of waiting request", rf_in_access, 1);
    check(rf_count >= 3, "R8 refresh occurred", rf_count, 3);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule